// File: doc/BRIEF.md
# Nibble-Addressed Divide-Ratio Loader

This block assembles the two divide ratios of a frequency synthesizer, a 14-bit feedback ratio N and a 12-bit reference ratio R, from a narrow parallel bus. The bus carries a 4-bit data nibble, a 3-bit address that picks one of seven nibble latches, and a strobe. The assembled words drive the downstream divider counters directly. Each word also has a flag that is high when its value is large enough for a counter to use.

The strobe is sampled on the system clock. At every clock edge where the strobe is high, the addressed latch takes the data nibble. The latch therefore follows the data for as long as the strobe stays high. When the strobe drops, the last value is frozen. A bus master that keeps the strobe low between transfers can drive any value on the data and address lines without disturbing either word.

Top module: `nib_div_loader`

## Requirements
- R1: A synchronous reset clears every latch, so both words read zero and both range flags read low in the cycle after reset.
- R2: At each clock edge where the strobe is high, the latch selected by the address takes the data nibble, and the word output shows it from the next cycle on. While the strobe stays high, the latch keeps following changes on the data lines.
- R3: At a clock edge where the strobe is low, no latch changes. The words hold the value from the last strobe-high edge.
- R4: The N word is built from the latches as follows. Address 0 supplies bits 3:0, address 1 supplies bits 7:4 and address 2 supplies bits 11:8. Address 3 supplies bits 13:12 from data bits 1:0; data bits 3:2 are discarded for that address.
- R5: The R word is built from the latches as follows. Address 4 supplies bits 3:0, address 5 supplies bits 7:4 and address 6 supplies bits 11:8.
- R6: Address 7 selects no latch. A strobe with address 7 leaves both words unchanged.
- R7: The N flag is high exactly when N is 3 or more.
- R8: The R flag is high exactly when R is 3 or more.
- R9: If the address changes while the strobe is held high, the latch that was selected before keeps the value it took at its last selected edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Transfer strobe; the addressed latch loads while it is high |
| addr_i | input | 3 | Latch select: 0 to 3 for N, 4 to 6 for R, 7 unused |
| data_i | input | 4 | Data nibble; bit 3 is the most significant |
| n_word_o | output | 14 | Assembled feedback divide ratio |
| n_ok_o | output | 1 | High when n_word_o is 3 or more |
| r_word_o | output | 12 | Assembled reference divide ratio |
| r_ok_o | output | 1 | High when r_word_o is 3 or more |

## Verification
Three situations are hard to reach from the ports: a write to the narrow top N latch with the upper data bits set, a strobe on the unused address, and an address change in the middle of a strobe-high burst. The vector table places each of these inside one continuous sequence. It sets data bits 3:2 high on address 3, strobes address 7 with a non-zero nibble, and walks the address from 1 to 2 without dropping the strobe. After each of these steps it compares both whole words. The directed tests then load N and R with 2 and then with 3, which exercises the edge of each range flag.

// File: rtl/nib_div_loader.sv
module nib_div_loader #(
  parameter int DATA_W  = 4,
  parameter int ADDR_W  = 3,
  parameter int N_W     = 14,
  parameter int R_W     = 12,
  parameter int MIN_DIV = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [N_W-1:0]    n_word_o,
  output logic              n_ok_o,
  output logic [R_W-1:0]    r_word_o,
  output logic              r_ok_o
);

  localparam int N_NIB = (N_W + DATA_W - 1) / DATA_W;
  localparam int R_NIB = (R_W + DATA_W - 1) / DATA_W;

  for (genvar g = 0; g < N_NIB; g++) begin : g_n
    localparam int LO = g * DATA_W;
    localparam int W  = (N_W - LO < DATA_W) ? (N_W - LO) : DATA_W;
    logic [W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (rst_i)                                   q <= '0;
      else if (stb_i && addr_i == ADDR_W'(g))      q <= data_i[W-1:0];
    end
    assign n_word_o[LO +: W] = q;
  end

  for (genvar g = 0; g < R_NIB; g++) begin : g_r
    localparam int LO = g * DATA_W;
    localparam int W  = (R_W - LO < DATA_W) ? (R_W - LO) : DATA_W;
    logic [W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (rst_i)                                   q <= '0;
      else if (stb_i && addr_i == ADDR_W'(N_NIB + g)) q <= data_i[W-1:0];
    end
    assign r_word_o[LO +: W] = q;
  end

  assign n_ok_o = n_word_o >= N_W'(MIN_DIV);
  assign r_ok_o = r_word_o >= R_W'(MIN_DIV);

  // R3: a low strobe freezes both words
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !stb_i |=> ($stable(n_word_o) && $stable(r_word_o)));

  // R2: lowest N nibble follows the bus under strobe
  a_r2_n_follow: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && addr_i == '0) |=> n_word_o[DATA_W-1:0] == $past(data_i));

  // R5: lowest R nibble follows the bus under strobe
  a_r5_r_follow: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && addr_i == ADDR_W'(N_NIB)) |=> r_word_o[DATA_W-1:0] == $past(data_i));

  // R4: the top N latch keeps only the low data bits
  a_r4_top_bits: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && addr_i == ADDR_W'(N_NIB - 1))
      |=> n_word_o[N_W-1:(N_NIB-1)*DATA_W] == $past(data_i[N_W-(N_NIB-1)*DATA_W-1:0]));

  // R6: the unused address disturbs nothing
  a_r6_spare_addr: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && addr_i >= ADDR_W'(N_NIB + R_NIB)) |=> ($stable(n_word_o) && $stable(r_word_o)));

endmodule

// File: tb/nib_div_loader_bench.sv
module nib_div_loader_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        stb = 0;
  logic [2:0]  addr = '0;
  logic [3:0]  data = '0;
  logic [13:0] n_word;
  logic [11:0] r_word;
  logic        n_ok, r_ok;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nib_div_loader u_nib_div_loader (
    .clk_i(clk), .rst_i(rst), .stb_i(stb), .addr_i(addr), .data_i(data),
    .n_word_o(n_word), .n_ok_o(n_ok), .r_word_o(r_word), .r_ok_o(r_ok));

  // {stb, addr, data, expected N, expected R}
  localparam logic [33:0] VEC [13] = '{
    {1'b1, 3'd0, 4'h5, 14'h0005, 12'h000},  // R2 load
    {1'b1, 3'd0, 4'hA, 14'h000A, 12'h000},  // R2 follow
    {1'b0, 3'd0, 4'h3, 14'h000A, 12'h000},  // R3 freeze
    {1'b1, 3'd1, 4'hC, 14'h00CA, 12'h000},  // R4 nibble 1
    {1'b1, 3'd2, 4'h7, 14'h07CA, 12'h000},  // R9 address moves under strobe
    {1'b1, 3'd3, 4'hF, 14'h37CA, 12'h000},  // R4 top bits only
    {1'b1, 3'd7, 4'h9, 14'h37CA, 12'h000},  // R6 spare address
    {1'b1, 3'd4, 4'h2, 14'h37CA, 12'h002},  // R5 nibble 0, R8 below range
    {1'b1, 3'd5, 4'hB, 14'h37CA, 12'h0B2},  // R5 nibble 1
    {1'b1, 3'd6, 4'hE, 14'h37CA, 12'hEB2},  // R5 nibble 2
    {1'b0, 3'd5, 4'h0, 14'h37CA, 12'hEB2},  // R3 freeze
    {1'b1, 3'd3, 4'h2, 14'h27CA, 12'hEB2},  // R4 top rewrite
    {1'b0, 3'd7, 4'hF, 14'h27CA, 12'hEB2}   // R3 idle bus
  };

  task automatic chk(input string req, input logic [13:0] en, input logic [11:0] er);
    logic ek_n, ek_r;
    ek_n = en >= 14'd3;
    ek_r = er >= 12'd3;
    checks++;
    if (n_word !== en || r_word !== er || n_ok !== ek_n || r_ok !== ek_r) begin
      fails++;
      $display("FAIL %s: got N=%h R=%h nok=%b rok=%b, expected N=%h R=%h nok=%b rok=%b",
               req, n_word, r_word, n_ok, r_ok, en, er, ek_n, ek_r);
    end
  endtask

  task automatic step(input logic s, input logic [2:0] a, input logic [3:0] d);
    stb = s; addr = a; data = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    stb = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset", 14'h0, 12'h0);

    for (int i = 0; i < 13; i++) begin
      step(VEC[i][33], VEC[i][32:30], VEC[i][29:26]);
      chk($sformatf("R2/R3/R4/R5/R6/R9 vec %0d", i), VEC[i][25:12], VEC[i][11:0]);
    end

    do_reset();
    chk("R1 reset after load", 14'h0, 12'h0);

    step(1, 3'd0, 4'h2); step(1, 3'd4, 4'h2); step(0, 3'd0, 4'h0);
    chk("R7 R8 value two", 14'h2, 12'h2);
    step(1, 3'd0, 4'h3); step(1, 3'd4, 4'h3); step(0, 3'd0, 4'h0);
    chk("R7 R8 value three", 14'h3, 12'h3);

    for (int a = 0; a < 7; a++) step(1, 3'(a), 4'hF);
    step(0, 3'd0, 4'h0);
    chk("R4 R5 R7 R8 maximum", 14'h3FFF, 12'hFFF);

    step(1, 3'd1, 4'h0); step(1, 3'd5, 4'h0); step(1, 3'd7, 4'h0);
    chk("R6 R9 clear middle nibbles", 14'h3F0F, 12'hF0F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule